// File: doc/BRIEF.md
# Fractional-Rate PWM Channel with Deferred Update

A single pulse-width-modulated output whose whole configuration sits in one 32-bit control word, written and read over a plain register port. The output rate comes from a phase accumulator that adds a programmable step on every clock. A carry out of its top bit marks the start of a new output cycle. The duty comes from an 8-bit divider code that encodes the off portion of each cycle: a larger code gives a shorter high time.

Software writes new timing values into shadow copies. While the channel runs, these values reach the active copies that drive the accumulator and compare only after software raises the update-request bit. The transfer then happens at the next cycle start, and the request bit clears itself. While the channel is disabled, the active copies follow the shadows on every clock, so the first cycle after enabling already uses the programmed values.

Top module: `frac_pwm_channel`

## Requirements
- R1: After a synchronous active-high reset, the read word is all zeros and `pwmOut` is low.
- R2: Bit 31 of the control word is the enable. While it reads 0, `pwmOut` is low and the accumulator is held at zero.
- R3: The read word holds enable at bit 31, the update request at bit 30, zeros above the step field, the shadow step in bits `BASE_BITS+7:8` and the shadow divider code in bits 7:0. Write data in the zero-filled bits is discarded.
- R4: The cycle position is the top 8 bits of the accumulator. `pwmOut` is high while the position is strictly greater than the active divider code. Starting from an accumulator of zero, the high clocks over 2^BASE_BITS clocks equal the number of k in 0..2^BASE_BITS-1 with ((k*step mod 2^BASE_BITS)>>(BASE_BITS-8)) > code.
- R5: A divider code of 255 keeps `pwmOut` low. A code of 0 drives it low only while the position is 0.
- R6: With step S, exactly S cycle starts happen in 2^BASE_BITS clocks. For S up to 64 and code 128, `pwmOut` shows S rising edges over that window.
- R7: With an active step of 0 and the channel enabled, the accumulator does not move and `pwmOut` stays constant.
- R8: A write without the update bit, while enabled and with no request pending, changes the read-back shadow fields but leaves `pwmOut` driven by the old active values.
- R9: Writing bit 30 as 1 sets the request flag. At the next accumulator carry, the shadows move to the active copies and the flag clears.
- R10: While a request is pending, a write leaves the shadow step and code unchanged. Its enable bit still takes effect, and the flag stays set.
- R11: While disabled, the active copies load the shadows every clock and any pending request clears on the next clock.
- R12: A pending request with an active step of 0 is applied on the next clock, so the block never stalls waiting for a carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word write data |
| rdData | output | 32 | Control word read data |
| pwmOut | output | 1 | PWM output |

## Verification
The assertions assume that `wrEn` and `wrData` are stable around the sampling edge, and that a write is a single-cycle pulse whose effect is visible on the next cycle. The carry-based checks also assume that an enable-off write can reset the accumulator at any time. The stimulus drives every write at the falling edge for exactly one cycle. It always loads a new configuration with the enable bit clear and then enables in a second write, which gives each duty and rate sweep a known accumulator start of zero. The long windows that wait for a carry use step 1, so the whole 2^BASE_BITS-clock wrap falls inside the observed span.

// File: rtl/pwm_frac_pkg.sv
package pwm_frac_pkg;
  localparam int ENABLE_BIT = 31;
  localparam int UPDATE_BIT = 30;
  localparam int CODE_W     = 8;

  typedef struct packed {
    logic loadActive;  // copy shadow timing into active copies
    logic clearAcc;    // force accumulator to zero
  } pwmStrobeT;
endpackage

// File: rtl/pwm_frac_ctrl.sv
module pwm_frac_ctrl
  import pwm_frac_pkg::*;
#(
  parameter int BASE_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [31:0]          wrData,
  input  logic                 cycleStart,
  input  logic                 activeBaseZero,
  output pwmStrobeT            strobe,
  output logic                 enQ,
  output logic [BASE_BITS-1:0] shadowBase,
  output logic [CODE_W-1:0]    shadowDiv,
  output logic [31:0]          rdData
);
  localparam int BASE_LSB = CODE_W;
  localparam int BASE_MSB = CODE_W + BASE_BITS - 1;
  localparam int PAD_W    = UPDATE_BIT - BASE_MSB - 1;

  logic flagQ;
  logic applyNow;
  logic unusedPad;

  assign unusedPad = ^wrData[UPDATE_BIT-1:BASE_MSB+1];

  // transfer: idle channel, or pending request at a carry / with frozen step
  assign applyNow = !enQ || (flagQ && (cycleStart || activeBaseZero));

  always_comb begin
    strobe.loadActive = applyNow;
    strobe.clearAcc   = !enQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ        <= 1'b0;
      flagQ      <= 1'b0;
      shadowBase <= '0;
      shadowDiv  <= '0;
    end else begin
      if (applyNow) flagQ <= 1'b0;
      if (wrEn) begin
        enQ <= wrData[ENABLE_BIT];
        if (wrData[UPDATE_BIT]) flagQ <= 1'b1;
        if (!flagQ) begin
          shadowBase <= wrData[BASE_MSB:BASE_LSB];
          shadowDiv  <= wrData[CODE_W-1:0];
        end
      end
    end
  end

  assign rdData = {enQ, flagQ, {PAD_W{1'b0}}, shadowBase, shadowDiv};
endmodule

// File: rtl/pwm_frac_datapath.sv
module pwm_frac_datapath
  import pwm_frac_pkg::*;
#(
  parameter int BASE_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pwmStrobeT            strobe,
  input  logic                 enable,
  input  logic [BASE_BITS-1:0] shadowBase,
  input  logic [CODE_W-1:0]    shadowDiv,
  output logic                 cycleStart,
  output logic                 activeBaseZero,
  output logic [BASE_BITS-1:0] accQ,
  output logic [CODE_W-1:0]    activeDiv,
  output logic                 pwmOut
);
  logic [BASE_BITS-1:0] activeBase;
  logic [BASE_BITS:0]   accSum;
  logic [CODE_W-1:0]    cyclePos;

  assign accSum         = {1'b0, accQ} + {1'b0, activeBase};
  assign cycleStart     = enable && accSum[BASE_BITS];
  assign activeBaseZero = (activeBase == '0);
  assign cyclePos       = accQ[BASE_BITS-1 -: CODE_W];
  assign pwmOut         = enable && (cyclePos > activeDiv);

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ       <= '0;
      activeBase <= '0;
      activeDiv  <= '0;
    end else begin
      if (strobe.clearAcc) accQ <= '0;
      else                 accQ <= accSum[BASE_BITS-1:0];
      if (strobe.loadActive) begin
        activeBase <= shadowBase;
        activeDiv  <= shadowDiv;
      end
    end
  end
endmodule

// File: rtl/frac_pwm_channel.sv
module frac_pwm_channel
  import pwm_frac_pkg::*;
#(
  parameter int BASE_BITS = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        pwmOut
);
  generate
    if (BASE_BITS < CODE_W || BASE_BITS > 21) begin : g_badWidth
      $error("BASE_BITS must lie in 8..21");
    end
  endgenerate

  pwmStrobeT            strobe;
  logic                 enQ;
  logic                 cycleStart;
  logic                 activeBaseZero;
  logic [BASE_BITS-1:0] shadowBase;
  logic [CODE_W-1:0]    shadowDiv;
  logic [BASE_BITS-1:0] accQ;
  logic [CODE_W-1:0]    activeDiv;

  pwm_frac_ctrl #(.BASE_BITS(BASE_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .cycleStart(cycleStart), .activeBaseZero(activeBaseZero),
    .strobe(strobe), .enQ(enQ), .shadowBase(shadowBase),
    .shadowDiv(shadowDiv), .rdData(rdData)
  );

  pwm_frac_datapath #(.BASE_BITS(BASE_BITS)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .enable(enQ),
    .shadowBase(shadowBase), .shadowDiv(shadowDiv),
    .cycleStart(cycleStart), .activeBaseZero(activeBaseZero),
    .accQ(accQ), .activeDiv(activeDiv), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_frac_checker.sv
module pwm_frac_checker #(
  parameter int BASE_BITS = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wrEn,
  input logic [31:0]          wrData,
  input logic [31:0]          rdData,
  input logic                 pwmOut,
  input logic                 cycleStart,
  input logic                 activeBaseZero,
  input logic [BASE_BITS-1:0] accQ,
  input logic [7:0]           activeDiv
);
  assert_disabled_low_R2: assert property (@(posedge clk) disable iff (rst)
    !rdData[31] |-> !pwmOut);

  assert_idle_acc_R2: assert property (@(posedge clk) disable iff (rst)
    !rdData[31] |=> accQ == '0);

  assert_off_code_R5: assert property (@(posedge clk) disable iff (rst)
    activeDiv == 8'hFF |-> !pwmOut);

  assert_frozen_acc_R7: assert property (@(posedge clk) disable iff (rst)
    (rdData[31] && activeBaseZero) |=> $stable(accQ));

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[30]) |=> rdData[30]);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (rdData[30] && rdData[31] && cycleStart && !(wrEn && wrData[30])) |=> !rdData[30]);

  assert_pending_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rdData[30] && wrEn) |=> $stable(rdData[BASE_BITS+7:0]));

  assert_enable_take_R10: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> rdData[31] == $past(wrData[31]));

  assert_zero_step_apply_R12: assert property (@(posedge clk) disable iff (rst)
    (rdData[30] && rdData[31] && activeBaseZero && !(wrEn && wrData[30])) |=> !rdData[30]);
endmodule

bind frac_pwm_channel pwm_frac_checker #(.BASE_BITS(BASE_BITS)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .pwmOut(pwmOut), .cycleStart(cycleStart), .activeBaseZero(activeBaseZero),
  .accQ(accQ), .activeDiv(activeDiv)
);

// File: tb/tb_frac_pwm_channel.sv
`timescale 1ns/1ps
module tb_frac_pwm_channel;
  localparam int BB   = 10;
  localparam int FULL = 1 << BB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        pwmOut;
  int          nTests = 0;
  int          nFail  = 0;
  bit          done   = 1'b0;

  always #2.5 clk = ~clk;

  frac_pwm_channel #(.BASE_BITS(BB)) dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pwmOut(pwmOut)
  );

  function automatic logic [31:0] mkWord(bit en, bit upd, int step, int code);
    logic [9:0] s;
    logic [7:0] c;
    s = step[9:0];
    c = code[7:0];
    return {en, upd, 12'b0, s, c};
  endfunction

  task automatic check(string req, int actual, int expected);
    nTests++;
    if (actual != expected) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic writeReg(logic [31:0] d);
    wrEn   = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn   = 1'b0;
    wrData = '0;
  endtask

  task automatic stepN(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R4/R5/R6: duty and rate sweep starting from accumulator zero
  task automatic runDuty(int step, int code);
    int highs, rises, expHigh;
    logic prev;
    writeReg(mkWord(0, 0, step, code));
    writeReg(mkWord(1, 0, step, code));
    highs = 0; rises = 0; prev = 1'b0;
    for (int i = 0; i < FULL; i++) begin
      if (pwmOut) highs++;
      if (pwmOut && !prev) rises++;
      prev = pwmOut;
      @(negedge clk);
    end
    expHigh = 0;
    for (int k = 0; k < FULL; k++)
      if ((((k * step) % FULL) >> (BB - 8)) > code) expHigh++;
    check($sformatf("R4 highs step=%0d code=%0d", step, code), highs, expHigh);
    if (code == 255) check("R5 code 255 never high", highs, 0);
    if (code == 0)   check("R5 code 0 high count", highs, expHigh);
    if (step <= 64 && code == 128)
      check($sformatf("R6 rising edges step=%0d", step), rises, step);
  endtask

  initial begin
    int steps [7] = '{1, 3, 4, 37, 64, 255, 1023};
    int codes [7] = '{0, 1, 64, 128, 200, 254, 255};
    int waited, highs;
    bit stayed;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 read word after reset", int'(rdData), 0);
    check("R1 output after reset", int'(pwmOut), 0);

    // R3: field layout, pad bits discarded
    writeReg(mkWord(0, 0, 10'h2A5, 8'h3C) | 32'h3FFC_0000);
    check("R3 read word layout", int'(rdData), int'(mkWord(0, 0, 10'h2A5, 8'h3C)));

    // R2: disabled keeps output low even with code 0
    writeReg(mkWord(0, 0, 37, 0));
    stayed = 1'b1;
    for (int i = 0; i < 100; i++) begin
      if (pwmOut) stayed = 1'b0;
      @(negedge clk);
    end
    check("R2 disabled output low", int'(stayed), 1);

    foreach (steps[si]) foreach (codes[ci]) runDuty(steps[si], codes[ci]);

    // R8: write without update does not reach the output
    writeReg(mkWord(0, 0, 1, 255));
    writeReg(mkWord(1, 0, 1, 255));
    stepN(20);
    check("R5 code 255 output low", int'(pwmOut), 0);
    writeReg(mkWord(1, 0, 1, 0));
    check("R8 shadow code read back", int'(rdData[7:0]), 0);
    highs = 0;
    for (int i = 0; i < FULL + 80; i++) begin
      if (pwmOut) highs++;
      @(negedge clk);
    end
    check("R8 output unaffected without update", highs, 0);

    // R9 / R10: request, ignored write while pending, apply at carry
    writeReg(mkWord(1, 1, 1, 0));
    check("R9 request flag set", int'(rdData[30]), 1);
    writeReg(mkWord(1, 1, 1, 200));
    check("R10 pending write keeps code", int'(rdData[7:0]), 0);
    check("R10 flag still set", int'(rdData[30]), 1);
    waited = 0;
    while (rdData[30] && waited < FULL + 20) begin
      @(negedge clk);
      waited++;
    end
    check("R9 flag cleared at carry", int'(rdData[30]), 0);
    stepN(8);
    check("R9 new code drives output", int'(pwmOut), 1);

    // R10 / R11: disabling while pending
    writeReg(mkWord(1, 1, 1, 50));
    check("R9 flag set again", int'(rdData[30]), 1);
    writeReg(mkWord(0, 0, 1, 90));
    check("R10 enable bit taken while pending", int'(rdData[31]), 0);
    check("R10 code unchanged while pending", int'(rdData[7:0]), 50);
    check("R2 output low after disable", int'(pwmOut), 0);
    @(negedge clk);
    check("R11 idle clears pending flag", int'(rdData[30]), 0);

    // R7 / R12: zero step freezes; request still applies
    writeReg(mkWord(0, 0, 0, 0));
    writeReg(mkWord(1, 0, 0, 0));
    stayed = 1'b1;
    for (int i = 0; i < 100; i++) begin
      if (pwmOut) stayed = 1'b0;
      @(negedge clk);
    end
    check("R7 zero step output constant", int'(stayed), 1);
    writeReg(mkWord(1, 1, 256, 0));
    check("R12 flag set with zero step", int'(rdData[30]), 1);
    @(negedge clk);
    check("R12 applied next clock", int'(rdData[30]), 0);
    @(negedge clk);
    check("R12 output running after apply", int'(pwmOut), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(190000 * 5);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule